// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block sits beside the host's memory path and steers every access that falls in the legacy window from 0xA0000 up to 0xFFFFF. For each access it says whether main DRAM serves it or whether it is forwarded to the expansion bus. It also says whether a write must be refused. Configuration arrives as single-byte writes on a small register port. The block keeps only the fields it needs out of those bytes.

The window has three parts. The top 64 KB (0xF0000 to 0xFFFFF) takes one 2-bit attribute code. The 192 KB below it (0xC0000 to 0xEFFFF) is divided into twelve 16 KB shadow segments, and each segment has its own 2-bit code. The lowest 128 KB (0xA0000 to 0xBFFFF) is a protected-memory window. It opens to DRAM either through a force-open bit or through an enable bit that works only while the system-management-mode input is high.

The outputs are combinational from the access address, the access direction, the mode input and the registered configuration. A configuration write therefore changes the decode from the first cycle after the clock edge that captures it.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset every shadow segment and the top region forward reads and writes to the bus (dramSel 0, wrBlocked 0). The protected window holds the value 0x02, which has both the force-open bit 6 and the mode-enable bit 3 clear, so it goes to the bus even when smmActive is high.
- R2: An address below 0xA0000 or at or above 0x100000 always gives dramSel 1 and wrBlocked 0.
- R3: Attribute code 3 sends both reads and writes to DRAM, with wrBlocked 0.
- R4: Attribute code 1 sends reads to DRAM. A write under code 1 gives dramSel 0 and wrBlocked 1.
- R5: Attribute code 2 sends reads to the bus (dramSel 0) and writes to DRAM (dramSel 1), with wrBlocked 0.
- R6: Attribute code 0 sends both reads and writes to the bus, with wrBlocked 0.
- R7: The top region 0xF0000–0xFFFFF takes its code from bits 5:4 of the byte written at offset 0x59. The other bits of that byte have no effect.
- R8: Shadow segment i (0..11) covers 0xC0000 + i·0x4000 up to the next 16 KB boundary. It takes its code from the byte at offset 0x5A + (i>>1): bits 1:0 for even i and bits 5:4 for odd i. Bits 3:2 and 7:6 have no effect.
- R9: The protected window 0xA0000–0xBFFFF goes to DRAM for reads and writes whenever bit 6 of the byte at offset 0x72 is set, whatever the value of smmActive.
- R10: When bit 6 of offset 0x72 is clear, the protected window goes to DRAM only while bit 3 is set and smmActive is high. It follows changes of smmActive in the same cycle, with no clock edge needed.
- R11: A configuration write takes effect on the outputs from the cycle after the clock edge that captures it. Writes to any offset other than 0x59–0x5F and 0x72 leave every output unchanged.
- R12: wrBlocked is asserted only for a write to a code-1 region, and never together with dramSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration byte value |
| smmActive | input | 1 | System-management mode is active |
| accAddr | input | ADDR_W (32) | Physical address of the current access |
| accWrite | input | 1 | 1 for a write access, 0 for a read |
| dramSel | output | 1 | Access is served by main DRAM |
| wrBlocked | output | 1 | Write is refused (read-only region) |

## Verification
The bench probes the first and last address of every shadow segment under a code pattern in which no two neighbouring segments share a code. A design that swapped nibbles, used the wrong byte or placed a segment edge off by one would therefore route some boundary address wrongly. The bench puts junk in the ignored bits of each attribute byte and writes to neighbouring and aliased offsets, so that a decoder matching too few address bits, or reading the wrong field, changes the routing of a probed address. The protected window is probed while the mode input toggles without a clock edge, to catch a design that registers the mode input or ignores it. The output is also sampled on the cycle of a write and on the cycle after it, to catch a decode that uses the incoming data before the clock edge has captured it.

// File: rtl/legacy_map_pkg.sv
package legacy_map_pkg;

  localparam int ATTR_BYTES   = 7;   // offsets ATTR_BASE_OFF .. +6
  localparam int SEG_COUNT    = 12;  // shadow segments
  localparam int SEG_IDX_W    = $clog2(SEG_COUNT);
  localparam int SEG_SHIFT    = 14;  // 16 KB segments
  localparam int CODE_W       = 2;
  localparam int NIBBLE_W     = 4;
  localparam int TOP_FIELD_LSB = 4;
  localparam int PROT_OPEN_BIT = 6;
  localparam int PROT_MODE_BIT = 3;

  localparam logic [7:0] ATTR_BASE_OFF = 8'h59;
  localparam logic [7:0] PROT_OFF      = 8'h72;

  localparam logic [31:0] LOW_BASE    = 32'h000A_0000;
  localparam logic [31:0] SHADOW_BASE = 32'h000C_0000;
  localparam logic [31:0] TOP_BASE    = 32'h000F_0000;
  localparam logic [31:0] WIN_END     = 32'h0010_0000;

  typedef enum logic [1:0] {
    RGN_OUTSIDE,
    RGN_PROT,
    RGN_SHADOW,
    RGN_TOP
  } region_e;

  typedef enum logic [CODE_W-1:0] {
    ATTR_BUS     = 2'd0,
    ATTR_RDONLY  = 2'd1,
    ATTR_WRONLY  = 2'd2,
    ATTR_RW      = 2'd3
  } attr_code_e;

  typedef struct packed {
    logic [ATTR_BYTES-1:0] attrLoad;
    logic                  protLoad;
    region_e               region;
    logic [SEG_IDX_W-1:0]  segIdx;
  } ctrl_strobes_t;

endpackage

// File: rtl/legacy_map_ctrl.sv
module legacy_map_ctrl
  import legacy_map_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [ADDR_W-1:0] accAddr,
  output ctrl_strobes_t     strobes
);

  localparam logic [ADDR_W-1:0] LOW_B    = ADDR_W'(LOW_BASE);
  localparam logic [ADDR_W-1:0] SHADOW_B = ADDR_W'(SHADOW_BASE);
  localparam logic [ADDR_W-1:0] TOP_B    = ADDR_W'(TOP_BASE);
  localparam logic [ADDR_W-1:0] END_B    = ADDR_W'(WIN_END);

  logic [ADDR_W-1:0] shadowOff;
  logic [ADDR_W-1:0] unusedOffBits;

  assign shadowOff     = accAddr - SHADOW_B;
  assign unusedOffBits = shadowOff;

  // Register-port decode: one load strobe per tracked byte
  genvar b;
  generate
    for (b = 0; b < ATTR_BYTES; b++) begin : g_attrDec
      assign strobes.attrLoad[b] = cfgWrEn && (cfgAddr == ATTR_BASE_OFF + 8'(b));
    end
  endgenerate
  assign strobes.protLoad = cfgWrEn && (cfgAddr == PROT_OFF);

  // Access classification
  always_comb begin
    strobes.segIdx = shadowOff[SEG_SHIFT +: SEG_IDX_W];
    if (accAddr < LOW_B || accAddr >= END_B)
      strobes.region = RGN_OUTSIDE;
    else if (accAddr < SHADOW_B)
      strobes.region = RGN_PROT;
    else if (accAddr < TOP_B)
      strobes.region = RGN_SHADOW;
    else
      strobes.region = RGN_TOP;
  end

endmodule

// File: rtl/legacy_map_dp.sv
module legacy_map_dp
  import legacy_map_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobes_t strobes,
  input  logic [7:0]    cfgWrData,
  input  logic          smmActive,
  input  logic          accWrite,
  output logic          dramSel,
  output logic          wrBlocked
);

  logic [CODE_W-1:0] topCode;
  logic [CODE_W-1:0] segCode [SEG_COUNT];
  logic              protOpen;
  logic              protModeEn;
  logic [1:0]        unusedData;
  logic [CODE_W-1:0] selCode;

  assign unusedData = {cfgWrData[7], cfgWrData[2]};

  // Top region code
  always_ff @(posedge clk) begin
    if (!rstN)
      topCode <= ATTR_BUS;
    else if (strobes.attrLoad[0])
      topCode <= cfgWrData[TOP_FIELD_LSB +: CODE_W];
  end

  // Shadow segment codes, two per byte
  genvar g;
  generate
    for (g = 0; g < SEG_COUNT; g++) begin : g_seg
      localparam int BYTE_IDX  = 1 + g / 2;
      localparam int FIELD_LSB = (g % 2) * NIBBLE_W;
      always_ff @(posedge clk) begin
        if (!rstN)
          segCode[g] <= ATTR_BUS;
        else if (strobes.attrLoad[BYTE_IDX])
          segCode[g] <= cfgWrData[FIELD_LSB +: CODE_W];
      end
    end
  endgenerate

  // Protected window control (reset value 0x02: both bits clear)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      protOpen   <= 1'b0;
      protModeEn <= 1'b0;
    end else if (strobes.protLoad) begin
      protOpen   <= cfgWrData[PROT_OPEN_BIT];
      protModeEn <= cfgWrData[PROT_MODE_BIT];
    end
  end

  // Lookup
  always_comb begin
    selCode = ATTR_BUS;
    if (strobes.region == RGN_TOP)
      selCode = topCode;
    else if (strobes.region == RGN_SHADOW && strobes.segIdx < SEG_IDX_W'(SEG_COUNT))
      selCode = segCode[strobes.segIdx];
  end

  always_comb begin
    dramSel   = 1'b0;
    wrBlocked = 1'b0;
    unique case (strobes.region)
      RGN_OUTSIDE: dramSel = 1'b1;
      RGN_PROT:    dramSel = protOpen || (protModeEn && smmActive);
      default: begin
        unique case (attr_code_e'(selCode))
          ATTR_RW:     dramSel = 1'b1;
          ATTR_RDONLY: begin
            dramSel   = !accWrite;
            wrBlocked = accWrite;
          end
          ATTR_WRONLY: dramSel = accWrite;
          default:     dramSel = 1'b0;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder
  import legacy_map_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              smmActive,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  output logic              dramSel,
  output logic              wrBlocked
);

  ctrl_strobes_t strobes;

  legacy_map_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .accAddr (accAddr),
    .strobes (strobes)
  );

  legacy_map_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cfgWrData (cfgWrData),
    .smmActive (smmActive),
    .accWrite  (accWrite),
    .dramSel   (dramSel),
    .wrBlocked (wrBlocked)
  );

endmodule

// File: rtl/legacy_region_decoder_chk.sv
module legacy_region_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [7:0]        cfgAddr,
  input logic [7:0]        cfgWrData,
  input logic              smmActive,
  input logic [ADDR_W-1:0] accAddr,
  input logic              accWrite,
  input logic              dramSel,
  input logic              wrBlocked
);

  logic outside, inProt, cfgHits;

  assign outside = (accAddr < ADDR_W'(32'h000A_0000)) || (accAddr >= ADDR_W'(32'h0010_0000));
  assign inProt  = (accAddr >= ADDR_W'(32'h000A_0000)) && (accAddr < ADDR_W'(32'h000C_0000));
  assign cfgHits = cfgWrEn && ((cfgAddr >= 8'h59 && cfgAddr <= 8'h5F) || cfgAddr == 8'h72);

  a_r2_outside_dram: assert property (@(posedge clk) disable iff (!rstN)
    outside |-> (dramSel && !wrBlocked));

  a_r12_block_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    wrBlocked |-> (accWrite && !dramSel));

  a_r9_force_open: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 8'h72 && cfgWrData[6]) |=> (!inProt || dramSel));

  a_r11_ignored_offsets: assert property (@(posedge clk) disable iff (!rstN)
    !cfgHits |=> (!($stable(accAddr) && $stable(accWrite) && $stable(smmActive))
                  || ($stable(dramSel) && $stable(wrBlocked))));

endmodule

bind legacy_region_decoder legacy_region_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgAddr   (cfgAddr),
  .cfgWrData (cfgWrData),
  .smmActive (smmActive),
  .accAddr   (accAddr),
  .accWrite  (accWrite),
  .dramSel   (dramSel),
  .wrBlocked (wrBlocked)
);

// File: tb/legacy_region_decoder_tb.sv
module legacy_region_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic        smmActive = 1'b0;
  logic [31:0] accAddr = 32'h0;
  logic        accWrite = 1'b0;
  logic        dramSel, wrBlocked;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  legacy_region_decoder #(.ADDR_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .smmActive(smmActive), .accAddr(accAddr),
    .accWrite(accWrite), .dramSel(dramSel), .wrBlocked(wrBlocked)
  );

  // Expected {dramSel, wrBlocked} for an attribute code (R3..R6)
  function automatic logic [1:0] expCode(input logic [1:0] code, input logic wr);
    case (code)
      2'd3:    return 2'b10;
      2'd1:    return wr ? 2'b01 : 2'b10;
      2'd2:    return wr ? 2'b10 : 2'b00;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] segPattern(input int i);
    return 2'((i * 3 + 1) & 3);
  endfunction

  task automatic probe(input logic [31:0] a, input logic wr, input logic [1:0] exp,
                       input string tag);
    accAddr  = a;
    accWrite = wr;
    #1;
    checks++;
    if ({dramSel, wrBlocked} !== exp) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b actual={dram,blk}=%b expected=%b",
               tag, a, wr, {dramSel, wrBlocked}, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] off, input logic [7:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = off; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic testReset();
    smmActive = 1'b1;
    probe(32'h000A_0000, 1'b0, 2'b00, "R1 prot window closed after reset");
    probe(32'h000C_0000, 1'b0, 2'b00, "R1 shadow read to bus");
    probe(32'h000E_C000, 1'b1, 2'b00, "R1 shadow write to bus");
    probe(32'h000F_FFFF, 1'b1, 2'b00, "R1 top write to bus");
    smmActive = 1'b0;
  endtask

  task automatic testOutside();
    probe(32'h0009_FFFF, 1'b1, 2'b10, "R2 below window");
    probe(32'h0010_0000, 1'b1, 2'b10, "R2 above window");
    probe(32'h0000_0000, 1'b0, 2'b10, "R2 zero address");
    probe(32'hFFFF_FFFF, 1'b0, 2'b10, "R2 top of space");
  endtask

  task automatic testTop();
    cfgWrite(8'h59, 8'hCF);
    probe(32'h000F_0000, 1'b0, 2'b00, "R7 junk bits ignored, code 0 R6");
    cfgWrite(8'h59, 8'h30);
    probe(32'h000F_0000, 1'b0, 2'b10, "R7 R3 top read");
    probe(32'h000F_FFFF, 1'b1, 2'b10, "R7 R3 top write");
    cfgWrite(8'h59, 8'h10);
    probe(32'h000F_8000, 1'b0, 2'b10, "R7 R4 top read");
    probe(32'h000F_8000, 1'b1, 2'b01, "R4 R12 top write blocked");
    cfgWrite(8'h59, 8'hE0);
    probe(32'h000F_0000, 1'b0, 2'b00, "R7 R5 top read");
    probe(32'h000F_0000, 1'b1, 2'b10, "R5 top write");
    probe(32'h000E_FFFF, 1'b1, 2'b00, "R8 top code not leaking into seg 11");
  endtask

  task automatic testShadow();
    for (int b = 0; b < 6; b++)
      cfgWrite(8'h5A + 8'(b), 8'hCC | {2'b00, segPattern(2*b+1), 2'b00, segPattern(2*b)});
    for (int i = 0; i < 12; i++) begin
      logic [31:0] base = 32'h000C_0000 + 32'(i) * 32'h4000;
      for (int w = 0; w < 2; w++) begin
        probe(base, w[0], expCode(segPattern(i), w[0]), $sformatf("R8 seg%0d first", i));
        probe(base + 32'h3FFF, w[0], expCode(segPattern(i), w[0]), $sformatf("R8 seg%0d last", i));
      end
    end
  endtask

  task automatic testLatency();
    // seg0 holds code 1 from the pattern; change it to code 3
    accAddr = 32'h000C_0000; accWrite = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 8'h5A; cfgWrData = 8'h03;
    probe(32'h000C_0000, 1'b1, 2'b01, "R11 old value before capture edge");
    @(negedge clk);
    cfgWrEn = 1'b0;
    probe(32'h000C_0000, 1'b1, 2'b10, "R11 new value after capture edge");
    probe(32'h000C_4000, 1'b1, 2'b00, "R11 R8 seg1 now code 0");
  endtask

  task automatic testIgnored();
    cfgWrite(8'h58, 8'hFF);
    cfgWrite(8'h60, 8'hFF);
    cfgWrite(8'h71, 8'hFF);
    cfgWrite(8'h73, 8'hFF);
    cfgWrite(8'hD9, 8'hFF);
    cfgWrite(8'hDA, 8'hFF);
    smmActive = 1'b1;
    probe(32'h000B_0000, 1'b0, 2'b00, "R11 prot window unchanged");
    smmActive = 1'b0;
    probe(32'h000C_0000, 1'b1, 2'b10, "R11 seg0 unchanged");
    probe(32'h000C_4000, 1'b0, 2'b00, "R11 seg1 unchanged");
    probe(32'h000F_0000, 1'b0, 2'b00, "R11 top unchanged");
    probe(32'h000E_8000, 1'b1, expCode(segPattern(10), 1'b1), "R11 seg10 unchanged");
  endtask

  task automatic testProt();
    cfgWrite(8'h72, 8'h08);
    smmActive = 1'b0;
    probe(32'h000A_0000, 1'b0, 2'b00, "R10 mode bit without mode");
    smmActive = 1'b1;
    probe(32'h000A_0000, 1'b0, 2'b10, "R10 mode bit with mode, no edge");
    probe(32'h000B_FFFF, 1'b1, 2'b10, "R10 write in mode");
    smmActive = 1'b0;
    probe(32'h000B_FFFF, 1'b1, 2'b00, "R10 mode dropped, no edge");
    cfgWrite(8'h72, 8'h40);
    probe(32'h000A_0000, 1'b1, 2'b10, "R9 force open without mode");
    smmActive = 1'b1;
    probe(32'h000B_8000, 1'b0, 2'b10, "R9 force open with mode");
    cfgWrite(8'h72, 8'hB7);
    probe(32'h000A_0000, 1'b0, 2'b00, "R10 R9 both bits clear in mode");
    probe(32'h000C_0000, 1'b1, 2'b10, "R10 mode does not touch shadow");
    smmActive = 1'b0;
  endtask

  task automatic testResetAgain();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    probe(32'h000C_0000, 1'b1, 2'b00, "R1 seg0 back to bus after reset");
    probe(32'h000F_0000, 1'b0, 2'b00, "R1 top back to bus after reset");
    smmActive = 1'b1;
    probe(32'h000A_0000, 1'b0, 2'b00, "R1 prot closed after reset");
    smmActive = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOutside();
    testTop();
    testShadow();
    testLatency();
    testIgnored();
    testProt();
    testResetAgain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule